// File: doc/BRIEF.md
# RTC Interrupt Event Emulator

This block recreates the three interrupt sources of a classic real-time clock: a once-per-second update event, a time-of-day alarm event and a periodic event at a programmable power-of-two rate. It uses one polling tick as its only time base. An external timer delivers the tick. The time-of-day counter supplies hours, minutes and seconds. The block then decides on each tick which events have occurred. It raises a single interrupt pulse and a 16-bit flags word that names them.

The block also tells the tick source how fast to run. The floor rate is 64 Hz. A faster rate is requested only while periodic events are enabled at a higher frequency. The periodic event is produced by dividing the tick count. When every event enable is clear, the block withdraws its tick request and ignores ticks. Rates and frequencies are carried as base-2 logarithms of a rate in Hz.

Top module: `rtc_event_emu`

## Requirements
- R1: `rate_log2_o` equals the clamped periodic code when `per_en_i` is set and that code is above 6. Otherwise it equals 6, which is 64 Hz. `per_code_i` is clamped into 1..13 (2 Hz to 8192 Hz) before use.
- R2: `tick_req_o` is high exactly when at least one of `upd_en_i`, `alm_en_i` or `per_en_i` is high.
- R3: On a processed tick with `upd_en_i` set, flag 0x10 is raised when `cur_sec_i` differs from the seconds value recorded at the previous processed tick or arm cycle. Every processed tick records `cur_sec_i`.
- R4: On each processed tick with `per_en_i` set, a tick counter advances. When it reaches 2^(rate_log2 - clamped code), flag 0x40 is raised and the counter restarts from zero. The counter holds while `per_en_i` is clear.
- R5: On a processed tick with `alm_en_i` set, flag 0x20 is raised when hours, minutes and seconds all equal the alarm inputs.
- R6: `irq_o` is high for the cycle after an edge that saw a processed tick with at least one event. In that cycle `flags_o` is {8'h01, 8'h80 | event flags}. In every other cycle `flags_o` is zero.
- R7: The first cycle with any enable set, after a cycle with all enables clear or after reset, is an arm cycle. It clears the periodic counter, records `cur_sec_i` and raises no event, even if a tick arrives in that cycle.
- R8: While all enables are clear, ticks are ignored and `irq_o` stays low.
- R9: Events occurring on the same tick are merged into one pulse whose low flag byte ORs their flags.
- R10: During and after reset, `irq_o` is low and `flags_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Polling tick strobe, one cycle wide |
| upd_en_i | input | 1 | Update event enable |
| alm_en_i | input | 1 | Alarm event enable |
| per_en_i | input | 1 | Periodic event enable |
| per_code_i | input | 4 | Periodic frequency as log2 Hz |
| cur_hr_i | input | 5 | Current hours |
| cur_min_i | input | 6 | Current minutes |
| cur_sec_i | input | 6 | Current seconds |
| alm_hr_i | input | 5 | Alarm hours |
| alm_min_i | input | 6 | Alarm minutes |
| alm_sec_i | input | 6 | Alarm seconds |
| tick_req_o | output | 1 | Tick source should run |
| rate_log2_o | output | 4 | Requested tick rate as log2 Hz |
| irq_o | output | 1 | Interrupt pulse |
| flags_o | output | 16 | Event count in [15:8], flags in [7:0] |

## Verification
A stale recorded seconds value shows up on the first processed tick: an update flag appears or goes missing in the very next cycle. A periodic counter with a wrong count or a missed clear on arming shifts every later periodic flag by a fixed number of ticks. The longest divisor, 32 ticks at 2 Hz, is walked in full so that such an offset becomes visible. An arm state that does not follow the enables causes either a spurious pulse on the arming tick or events while all enables are off. Both are visible on `irq_o` one cycle after the tick.

// File: rtl/rte_pkg.sv
package rte_pkg;
  localparam logic [7:0] FLAG_IRQ = 8'h80;
  localparam logic [7:0] FLAG_PF  = 8'h40;
  localparam logic [7:0] FLAG_AF  = 8'h20;
  localparam logic [7:0] FLAG_UF  = 8'h10;
  localparam logic [7:0] EVT_ONE  = 8'h01;

  function automatic logic [15:0] mk_flags(logic uf, logic af, logic pf);
    logic [7:0] lo;
    lo = FLAG_IRQ | (uf ? FLAG_UF : 8'h00) | (af ? FLAG_AF : 8'h00) |
         (pf ? FLAG_PF : 8'h00);
    return {EVT_ONE, lo};
  endfunction
endpackage

// File: rtl/rte_rate_sel.sv
module rte_rate_sel #(
  parameter int CODE_W    = 4,
  parameter int MIN_LOG2  = 1,
  parameter int MAX_LOG2  = 13,
  parameter int BASE_LOG2 = 6,
  parameter int CNT_W     = 6
) (
  input  logic              per_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] rate_o,
  output logic [CNT_W-1:0]  div_o
);
  localparam logic [CODE_W-1:0] LO   = CODE_W'(MIN_LOG2);
  localparam logic [CODE_W-1:0] HI   = CODE_W'(MAX_LOG2);
  localparam logic [CODE_W-1:0] BASE = CODE_W'(BASE_LOG2);

  logic [CODE_W-1:0] code_c;
  logic [CODE_W-1:0] shift;

  always_comb begin
    if (code_i < LO)      code_c = LO;
    else if (code_i > HI) code_c = HI;
    else                  code_c = code_i;
    rate_o = (per_en_i && code_c > BASE) ? code_c : BASE;
    shift  = rate_o - code_c;
    div_o  = CNT_W'(1) << shift;
  end
endmodule

// File: rtl/rte_per_div.sv
module rte_per_div #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;
  // >= covers a divisor that shrank below the running count
  assign hit_o   = step_i && (cnt_nxt >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= hit_o ? '0 : cnt_nxt;
  end
endmodule

// File: rtl/rte_time_cmp.sv
module rte_time_cmp #(
  parameter int HR_W  = 5,
  parameter int MIN_W = 6,
  parameter int SEC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             upd_en_i,
  input  logic             alm_en_i,
  input  logic [HR_W-1:0]  cur_hr_i,
  input  logic [MIN_W-1:0] cur_min_i,
  input  logic [SEC_W-1:0] cur_sec_i,
  input  logic [HR_W-1:0]  alm_hr_i,
  input  logic [MIN_W-1:0] alm_min_i,
  input  logic [SEC_W-1:0] alm_sec_i,
  output logic             upd_hit_o,
  output logic             alm_hit_o
);
  logic [SEC_W-1:0] last_sec_q;
  logic             tod_match;

  assign tod_match = (cur_hr_i == alm_hr_i) && (cur_min_i == alm_min_i) &&
                     (cur_sec_i == alm_sec_i);
  assign upd_hit_o = step_i && upd_en_i && (cur_sec_i != last_sec_q);
  assign alm_hit_o = step_i && alm_en_i && tod_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 last_sec_q <= '0;
    else if (load_i || step_i)   last_sec_q <= cur_sec_i;
  end
endmodule

// File: rtl/rtc_event_emu.sv
module rtc_event_emu #(
  parameter int CODE_W    = 4,
  parameter int MIN_LOG2  = 1,
  parameter int MAX_LOG2  = 13,
  parameter int BASE_LOG2 = 6,
  parameter int HR_W      = 5,
  parameter int MIN_W     = 6,
  parameter int SEC_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              upd_en_i,
  input  logic              alm_en_i,
  input  logic              per_en_i,
  input  logic [CODE_W-1:0] per_code_i,
  input  logic [HR_W-1:0]   cur_hr_i,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [SEC_W-1:0]  cur_sec_i,
  input  logic [HR_W-1:0]   alm_hr_i,
  input  logic [MIN_W-1:0]  alm_min_i,
  input  logic [SEC_W-1:0]  alm_sec_i,
  output logic              tick_req_o,
  output logic [CODE_W-1:0] rate_log2_o,
  output logic              irq_o,
  output logic [15:0]       flags_o
);
  import rte_pkg::*;

  localparam int DIV_MAX = 1 << (BASE_LOG2 - MIN_LOG2);
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  logic             any_en, armed_q, arm, step;
  logic             uf, af, pf;
  logic [CNT_W-1:0] div;
  logic             irq_q;
  logic [15:0]      flags_q;

  assign any_en     = upd_en_i | alm_en_i | per_en_i;
  assign arm        = any_en & ~armed_q;
  assign step       = tick_i & any_en & armed_q;
  assign tick_req_o = any_en;

  rte_rate_sel #(
    .CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2),
    .BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)
  ) u_rate (
    .per_en_i(per_en_i), .code_i(per_code_i), .rate_o(rate_log2_o), .div_o(div)
  );

  rte_per_div #(.CNT_W(CNT_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(arm), .step_i(step & per_en_i),
    .div_i(div), .hit_o(pf)
  );

  rte_time_cmp #(.HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)) u_tod (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(arm), .step_i(step),
    .upd_en_i(upd_en_i), .alm_en_i(alm_en_i),
    .cur_hr_i(cur_hr_i), .cur_min_i(cur_min_i), .cur_sec_i(cur_sec_i),
    .alm_hr_i(alm_hr_i), .alm_min_i(alm_min_i), .alm_sec_i(alm_sec_i),
    .upd_hit_o(uf), .alm_hit_o(af)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      armed_q <= any_en;
      irq_q   <= uf | af | pf;
      flags_q <= (uf | af | pf) ? mk_flags(uf, af, pf) : 16'h0000;
    end
  end

  assign irq_o   = irq_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/rte_checker.sv
module rte_checker #(
  parameter int CODE_W    = 4,
  parameter int BASE_LOG2 = 6,
  parameter int HR_W      = 5,
  parameter int MIN_W     = 6,
  parameter int SEC_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              upd_en_i,
  input logic              alm_en_i,
  input logic              per_en_i,
  input logic [HR_W-1:0]   cur_hr_i,
  input logic [MIN_W-1:0]  cur_min_i,
  input logic [SEC_W-1:0]  cur_sec_i,
  input logic [HR_W-1:0]   alm_hr_i,
  input logic [MIN_W-1:0]  alm_min_i,
  input logic [SEC_W-1:0]  alm_sec_i,
  input logic [CODE_W-1:0] rate_log2_o,
  input logic              irq_o,
  input logic [15:0]       flags_o
);
  logic any_en, match;
  assign any_en = upd_en_i | alm_en_i | per_en_i;
  assign match  = (cur_hr_i == alm_hr_i) && (cur_min_i == alm_min_i) &&
                  (cur_sec_i == alm_sec_i);

  AST_RATE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_log2_o >= CODE_W'(BASE_LOG2)); // R1
  AST_RATE_NO_PER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_en_i |-> rate_log2_o == CODE_W'(BASE_LOG2)); // R1
  AST_UF_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !upd_en_i |=> !flags_o[4]); // R3
  AST_PF_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !per_en_i |=> !flags_o[6]); // R4
  AST_AF_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alm_en_i && match) |=> !flags_o[5]); // R5
  AST_IRQ_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags_o[15:8] == 8'h01 && flags_o[7] && flags_o[6:4] != 3'b000
              && flags_o[3:0] == 4'h0); // R6
  AST_QUIET_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> flags_o == 16'h0000); // R6
  AST_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !irq_o); // R6
  AST_ARM_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en && !$past(any_en) |=> !irq_o); // R7
  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en |=> !irq_o); // R8
endmodule

bind rtc_event_emu rte_checker #(
  .CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2), .HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .upd_en_i(upd_en_i), .alm_en_i(alm_en_i), .per_en_i(per_en_i),
  .cur_hr_i(cur_hr_i), .cur_min_i(cur_min_i), .cur_sec_i(cur_sec_i),
  .alm_hr_i(alm_hr_i), .alm_min_i(alm_min_i), .alm_sec_i(alm_sec_i),
  .rate_log2_o(rate_log2_o), .irq_o(irq_o), .flags_o(flags_o)
);

// File: tb/sim_rtc_event_emu.sv
module sim_rtc_event_emu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // {tick, en{per,alm,upd}, code, sec, exp_irq, exp_flags_lo}; alarm 1:2:3, now 1:2:sec
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 3'b000, 4'd6, 6'd5, 1'b0, 8'h00},  // R8 disabled tick
    {1'b1, 3'b001, 4'd6, 6'd5, 1'b0, 8'h00},  // R7 arm with tick
    {1'b1, 3'b001, 4'd6, 6'd5, 1'b0, 8'h00},  // R3 same second
    {1'b1, 3'b001, 4'd6, 6'd6, 1'b1, 8'h90},  // R3 second changed
    {1'b0, 3'b001, 4'd6, 6'd7, 1'b0, 8'h00},  // R6 no tick
    {1'b1, 3'b001, 4'd6, 6'd7, 1'b1, 8'h90},  // R3
    {1'b1, 3'b010, 4'd6, 6'd3, 1'b1, 8'hA0},  // R5 alarm match
    {1'b1, 3'b010, 4'd6, 6'd4, 1'b0, 8'h00},  // R5 mismatch
    {1'b1, 3'b011, 4'd6, 6'd3, 1'b1, 8'hB0},  // R9 update+alarm
    {1'b1, 3'b000, 4'd6, 6'd9, 1'b0, 8'h00},  // R8
    {1'b1, 3'b100, 4'd5, 6'd9, 1'b0, 8'h00},  // R7 arm periodic
    {1'b1, 3'b100, 4'd5, 6'd9, 1'b0, 8'h00},  // R4 count 1 of 2
    {1'b1, 3'b100, 4'd5, 6'd9, 1'b1, 8'hC0},  // R4 divide by 2
    {1'b1, 3'b100, 4'd5, 6'd9, 1'b0, 8'h00},  // R4
    {1'b1, 3'b100, 4'd5, 6'd9, 1'b1, 8'hC0},  // R4
    {1'b1, 3'b100, 4'd8, 6'd9, 1'b1, 8'hC0},  // R4 fast rate, every tick
    {1'b1, 3'b100, 4'd8, 6'd9, 1'b1, 8'hC0},  // R4
    {1'b1, 3'b111, 4'd6, 6'd3, 1'b1, 8'hF0}   // R9 all three
  };

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic upd_en = 1'b0, alm_en = 1'b0, per_en = 1'b0;
  logic [3:0] code = 4'd6;
  logic [4:0] hr = 5'd1;
  logic [5:0] mn = 6'd2, sec = 6'd0;
  logic tick_req, irq;
  logic [3:0] rate;
  logic [15:0] flags;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_event_emu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .upd_en_i(upd_en), .alm_en_i(alm_en), .per_en_i(per_en), .per_code_i(code),
    .cur_hr_i(hr), .cur_min_i(mn), .cur_sec_i(sec),
    .alm_hr_i(5'd1), .alm_min_i(6'd2), .alm_sec_i(6'd3),
    .tick_req_o(tick_req), .rate_log2_o(rate), .irq_o(irq), .flags_o(flags)
  );

  task automatic check(input logic [16:0] act, input logic [16:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic [2:0] en, input logic [3:0] c,
                     input logic [5:0] s);
    tick = t; {per_en, alm_en, upd_en} = en; code = c; sec = s;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({irq, flags}, 17'h0, "R10 reset");
    check({13'h0, rate}, 17'd6, "R1 reset rate");
    check({16'h0, tick_req}, 17'd0, "R2 reset req");
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [22:0] v;
      v = VEC[i];
      cyc(v[22], v[21:19], v[18:15], v[14:9]);
      check({irq, flags}, {v[8], v[8] ? 8'h01 : 8'h00, v[7:0]}, $sformatf("R3-vector %0d", i));
    end

    // R1 rate selection and clamping
    {per_en, alm_en, upd_en} = 3'b100; code = 4'd13; #1;
    check({13'h0, rate}, 17'd13, "R1 code 13");
    code = 4'd15; #1;
    check({13'h0, rate}, 17'd13, "R1 clamp high");
    code = 4'd0; #1;
    check({13'h0, rate}, 17'd6, "R1 clamp low");
    per_en = 1'b0; code = 4'd10; #1;
    check({13'h0, rate}, 17'd6, "R1 periodic off");
    // R2 tick request
    alm_en = 1'b1; #1;
    check({16'h0, tick_req}, 17'd1, "R2 alarm only");
    alm_en = 1'b0; #1;
    check({16'h0, tick_req}, 17'd0, "R2 none");

    // R4 longest divisor: 2 Hz at 64 Hz base = 32 ticks
    cyc(1'b0, 3'b000, 4'd1, 6'd0);
    cyc(1'b1, 3'b100, 4'd1, 6'd0);           // R7 arm
    check({irq, flags}, 17'h0, "R7 arm periodic");
    for (int k = 1; k < 32; k++) begin
      cyc(1'b1, 3'b100, 4'd1, 6'd0);
      if (irq) check({irq, flags}, 17'h0, "R4 early periodic");
    end
    checks++;
    cyc(1'b1, 3'b100, 4'd1, 6'd0);
    check({irq, flags}, {1'b1, 16'h01C0}, "R4 32nd tick");

    // R10 reset mid-run clears outputs
    tick = 1'b1; @(posedge clk); #1;
    rst_ni = 1'b0; #1;
    check({irq, flags}, 17'h0, "R10 async reset");
    tick = 1'b0;
    @(negedge clk);
    check({irq, flags}, 17'h0, "R10 held in reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule